// File: doc/BRIEF.md
# Stepped Soft-Start Reference Sequencer

This block brings a switching regulator up in an orderly way. Nothing moves until the supply has been judged valid and the converter has been enabled. After both hold, the block enters a fixed waiting phase. During this phase it raises a hold output that pins the error amplifier just below the modulator ramp, and it keeps the reference code at zero.

When the wait is over, the block raises a reference code for an external DAC as a staircase. It climbs from zero to full scale in equal steps. The length of each step is a fixed number of switching-cycle ticks, so the ramp time scales with the switching frequency. With 64 ticks per step and 32 steps, the ramp lasts about 6.8 ms at 300 kHz and 3.4 ms at 600 kHz. On a 0.6 V full scale, each code step is 18.75 mV.

At full scale the block raises its done flag and holds the code there. If the enable or the supply-valid input drops at any point, the block returns at once to its idle state with the code at zero.

Top module: `softstart_seq`

## Requirements
- R1: While supply_ok_i is low, the outputs are ref_code_o = 0, amp_hold_o = 0 and done_o = 0, whatever en_i and tick_i do, and the sequence makes no progress.
- R2: While en_i is low, the outputs stay at zero and no phase is entered. One clock edge after en_i and supply_ok_i are both seen high in the idle state, amp_hold_o is 1.
- R3: amp_hold_o stays 1 and ref_code_o stays 0 for exactly DELAY_TICKS clock edges on which tick_i is high. The edge that accepts the last of those ticks drops amp_hold_o.
- R4: After the delay, ref_code_o rises by exactly 1 once for every STEP_TICKS accepted ticks. Clock edges with tick_i low do not count, and the code never jumps by more than 1 in a cycle.
- R5: When ref_code_o reaches NUM_STEPS (32 by default), done_o becomes 1 in the same cycle. Both then hold for as long as en_i and supply_ok_i stay high.
- R6: When en_i or supply_ok_i is low at a clock edge, in any phase, the next cycle shows ref_code_o = 0, amp_hold_o = 0 and done_o = 0. A later restart runs the full delay again from the beginning.
- R7: amp_hold_o and done_o are never 1 together, and ref_code_o never exceeds NUM_STEPS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Converter enable |
| supply_ok_i | input | 1 | Supply valid (undervoltage lockout released) |
| tick_i | input | 1 | One-clock pulse per switching cycle |
| ref_code_o | output | CODE_W (6) | Reference code to the DAC, 0 to NUM_STEPS |
| amp_hold_o | output | 1 | Clamp request for the error amplifier during the delay |
| done_o | output | 1 | Start-up complete, reference at full scale |

## Verification
The bench drives the tick input with three patterns: a tick on every clock, a tick on every third clock, and ticks at random. A design that counted clocks instead of ticks would step too early under the sparse patterns. The bench drops enable and supply-valid in the middle of the delay and of the ramp. A design that left a counter unreset would restart with a short delay, or resume from a nonzero code. The bench also checks the step from code 31 to 32 and the hold after it. A design off by one there would stop at 31, overshoot to 33, or raise done a cycle early or late.

// File: rtl/ss_pkg.sv
// Package ss_pkg
// Shared phase encoding for the soft-start sequencer.
// Assumes: none; types only.
package ss_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DELAY = 2'd1,
        PH_RAMP  = 2'd2,
        PH_DONE  = 2'd3
    } ss_phase_e;
endpackage

// File: rtl/ss_tick_counter.sv
// Module ss_tick_counter
// Counts accepted ticks modulo LIMIT and flags the tick that completes a period.
// Assumes: LIMIT >= 1; clr_i has priority over counting; the wrap flag is
// combinational and valid in the cycle of the completing tick.
module ss_tick_counter #(
    parameter int LIMIT = 64,
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    input  logic tick_i,
    output logic wrap_o
);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Flags the tick that lands on the last count of the period.
    always_comb begin
        wrap_o = run_i && tick_i && (cnt_q == LAST);
    end

    // Advances on accepted ticks and wraps at the end of each period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (run_i && tick_i) begin
            cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ss_phase_ctrl.sv
// Module ss_phase_ctrl
// Phase controller: idle -> delay -> ramp -> done, with the reference code register.
// Assumes: go_i is the combined enable and supply-valid condition; its loss
// forces idle from any phase; the wrap inputs come from the tick counters.
module ss_phase_ctrl
    import ss_pkg::*;
#(
    parameter int NUM_STEPS = 32,
    parameter int CODE_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic              delay_wrap_i,
    input  logic              step_wrap_i,
    output ss_phase_e         phase_o,
    output logic [CODE_W-1:0] code_o
);
    localparam logic [CODE_W-1:0] CODE_TOP  = CODE_W'(NUM_STEPS);
    localparam logic [CODE_W-1:0] CODE_LAST = CODE_W'(NUM_STEPS - 1);

    ss_phase_e         phase_q, phase_d;
    logic [CODE_W-1:0] code_q, code_d;

    // Chooses the next phase and code from the current phase and counter flags.
    always_comb begin
        phase_d = phase_q;
        code_d  = code_q;
        if (!go_i) begin
            phase_d = PH_IDLE;
            code_d  = '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    phase_d = PH_DELAY;
                    code_d  = '0;
                end
                PH_DELAY: begin
                    if (delay_wrap_i) phase_d = PH_RAMP;
                end
                PH_RAMP: begin
                    if (step_wrap_i) begin
                        code_d = code_q + 1'b1;
                        if (code_q == CODE_LAST) phase_d = PH_DONE;
                    end
                end
                PH_DONE: begin
                    code_d = CODE_TOP;
                end
                default: begin
                    phase_d = PH_IDLE;
                    code_d  = '0;
                end
            endcase
        end
    end

    // Registers phase and code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            code_q  <= '0;
        end else begin
            phase_q <= phase_d;
            code_q  <= code_d;
        end
    end

    assign phase_o = phase_q;
    assign code_o  = code_q;
endmodule

// File: rtl/softstart_seq.sv
// Module softstart_seq
// Top of the stepped soft-start sequencer: gates start-up on enable and supply
// valid, holds the amplifier through a tick-counted delay, then steps the
// reference code up to NUM_STEPS at STEP_TICKS ticks per step.
// Assumes: tick_i is a single-clock pulse per switching cycle, synchronous to clk.
module softstart_seq
    import ss_pkg::*;
#(
    parameter int DELAY_TICKS = 120000,
    parameter int STEP_TICKS  = 64,
    parameter int NUM_STEPS   = 32,
    localparam int CODE_W = $clog2(NUM_STEPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              supply_ok_i,
    input  logic              tick_i,
    output logic [CODE_W-1:0] ref_code_o,
    output logic              amp_hold_o,
    output logic              done_o
);
    ss_phase_e phase;
    logic      go;
    logic      delay_wrap, step_wrap;
    logic      in_delay, in_ramp;

    // Combines the start conditions and decodes the phase.
    always_comb begin
        go       = en_i && supply_ok_i;
        in_delay = (phase == PH_DELAY);
        in_ramp  = (phase == PH_RAMP);
    end

    ss_tick_counter #(.LIMIT(DELAY_TICKS)) u_delay_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (!go || !in_delay),
        .run_i  (in_delay),
        .tick_i (tick_i),
        .wrap_o (delay_wrap)
    );

    ss_tick_counter #(.LIMIT(STEP_TICKS)) u_step_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (!go || !in_ramp),
        .run_i  (in_ramp),
        .tick_i (tick_i),
        .wrap_o (step_wrap)
    );

    ss_phase_ctrl #(.NUM_STEPS(NUM_STEPS), .CODE_W(CODE_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .go_i         (go),
        .delay_wrap_i (delay_wrap),
        .step_wrap_i  (step_wrap),
        .phase_o      (phase),
        .code_o       (ref_code_o)
    );

    // Drives the status outputs from the registered phase.
    always_comb begin
        amp_hold_o = in_delay;
        done_o     = (phase == PH_DONE);
    end
endmodule

// File: rtl/ss_checker.sv
// Module ss_checker
// Port-level properties of the soft-start sequencer, bound to softstart_seq.
// Assumes: synchronous active-low reset; all checks are disabled during reset.
module ss_checker #(
    parameter int NUM_STEPS = 32,
    parameter int CODE_W    = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_i,
    input logic              supply_ok_i,
    input logic [CODE_W-1:0] ref_code_o,
    input logic              amp_hold_o,
    input logic              done_o
);
    p_off_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_i && supply_ok_i) |=> (ref_code_o == '0 && !amp_hold_o && !done_o));

    p_no_supply_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok_i |=> (ref_code_o == '0 && !amp_hold_o && !done_o));

    p_hold_zero_ref_r3: assert property (@(posedge clk) disable iff (!rst_n)
        amp_hold_o |-> ref_code_o == '0);

    p_unit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && supply_ok_i) |=>
            (ref_code_o == $past(ref_code_o) || ref_code_o == $past(ref_code_o) + 1'b1));

    p_done_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ref_code_o == CODE_W'(NUM_STEPS));

    p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && en_i && supply_ok_i) |=> done_o);

    p_excl_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({amp_hold_o, done_o}));

    p_code_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ref_code_o <= CODE_W'(NUM_STEPS));
endmodule

bind softstart_seq ss_checker #(.NUM_STEPS(NUM_STEPS), .CODE_W(CODE_W)) u_ss_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .supply_ok_i (supply_ok_i),
    .ref_code_o  (ref_code_o),
    .amp_hold_o  (amp_hold_o),
    .done_o      (done_o)
);

// File: tb/softstart_seq_test.sv
module softstart_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int DLY   = 10;
    localparam int STEP  = 64;
    localparam int NSTEP = 32;
    localparam int CW    = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          ok = 1'b0;
    logic          tick = 1'b0;
    logic [CW-1:0] code;
    logic          hold;
    logic          done;

    int n_cmp = 0;
    int n_bad = 0;
    int tick_mode = 0;   // 0: every clock, 1: every third clock, 2: random
    int tick_div = 0;
    bit finished = 1'b0;

    // Reference model state.
    int m_phase = 0;     // 0 idle, 1 delay, 2 ramp, 3 done
    int m_ticks = 0;
    int m_code = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    softstart_seq #(.DELAY_TICKS(DLY), .STEP_TICKS(STEP), .NUM_STEPS(NSTEP)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en),
        .supply_ok_i (ok),
        .tick_i      (tick),
        .ref_code_o  (code),
        .amp_hold_o  (hold),
        .done_o      (done)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n || !(en && ok)) begin
            m_phase = 0; m_ticks = 0; m_code = 0;
        end else if (m_phase == 0) begin
            m_phase = 1; m_ticks = 0;
        end else if (m_phase == 1) begin
            if (tick) m_ticks++;
            if (m_ticks == DLY) begin m_phase = 2; m_ticks = 0; end
        end else if (m_phase == 2) begin
            if (tick) m_ticks++;
            if (m_ticks == STEP) begin
                m_ticks = 0; m_code++;
                if (m_code == NSTEP) m_phase = 3;
            end
        end
    end

    // Compares every output with the model on the falling edge; drives the tick.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            string tag;
            case (m_phase)
                0: tag = ok ? "R2 idle" : "R1 idle";
                1: tag = "R3 delay";
                2: tag = "R4 ramp";
                default: tag = "R5 done";
            endcase
            check({tag, " code"}, int'(code), m_code);
            check({tag, " hold"}, int'(hold), int'(m_phase == 1));
            check({tag, " done"}, int'(done), int'(m_phase == 3));
            check("R7 flags exclusive", int'(hold && done), 0);
        end
        tick_div = (tick_div + 1) % 3;
        case (tick_mode)
            0: tick <= 1'b1;
            1: tick <= (tick_div == 0);
            default: tick <= ($urandom_range(0, 1) == 1);
        endcase
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit && !done; i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        finished = 1'b1;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        cycles(3);
        rst_n <= 1'b1;
        cycles(1);
        check("R1 reset code", int'(code), 0);
        check("R1 reset hold", int'(hold), 0);
        // R1: enable without supply does nothing.
        en <= 1'b1; ok <= 1'b0;
        cycles(30);
        check("R1 no supply code", int'(code), 0);
        check("R1 no supply hold", int'(hold), 0);
        // R2: supply without enable does nothing.
        en <= 1'b0; ok <= 1'b1;
        cycles(30);
        check("R2 no enable hold", int'(hold), 0);
        en <= 1'b1;
        cycles(2);
        check("R2 start hold", int'(hold), 1);
        // Full ramp, tick on every clock.
        wait_done(4000);
        check("R5 done reached", int'(done), 1);
        check("R5 full code", int'(code), NSTEP);
        cycles(40);
        check("R5 done holds", int'(done), 1);
        // R6: drop enable in done.
        en <= 1'b0;
        cycles(1);
        check("R6 abort code", int'(code), 0);
        check("R6 abort done", int'(done), 0);
        // Sparse ticks, abort mid-ramp by supply loss.
        tick_mode = 1;
        en <= 1'b1;
        cycles(DLY * 3 + 600);
        check("R4 mid ramp nonzero", int'(code != 0), 1);
        ok <= 1'b0;
        cycles(1);
        check("R6 supply loss code", int'(code), 0);
        ok <= 1'b1;
        cycles(2);
        check("R6 restart hold", int'(hold), 1);
        // Abort in the delay phase, then restart with random ticks.
        cycles(5);
        en <= 1'b0;
        cycles(1);
        check("R6 delay abort hold", int'(hold), 0);
        tick_mode = 2;
        en <= 1'b1;
        wait_done(20000);
        check("R5 random done", int'(done), 1);
        check("R7 code bound", int'(code), NSTEP);
        cycles(10);
        finished = 1'b1;
        summary();
    end
endmodule